// File: doc/BRIEF.md
# Loop Delay Meter

This block measures how long a bit stream takes to go through an external path and come back. The path is the system under test. The block sees two serial streams on the same bit clock: the bit it sends out and the bit it receives back. Each bit period is marked by a one-cycle `bit_en` strobe. The lock logic raises `sync_ok` once the received stream is aligned with the local generator. At that point the block records a window of `PAT_W` consecutive transmitted bits as a signature.

The measurement then runs in three steps:
- A comparator on the transmit side looks for the signature in the transmit window. When it finds it, a bit-period counter starts.
- A second comparator watches the receive window. When the signature appears there, the counter stops.
- The count is reported as the loop delay in bit periods. The valid flag is held with it.

If the signature does not come back within `TMO_LIMIT` bit periods, the measurement ends with a timeout flag instead. Dropping `sync_ok` abandons any run or result. Raising it again starts a fresh measurement.

Top module: `loop_delay_meter`

## Requirements
- R1: After reset, `dly_valid` and `dly_timeout` are 0 and `dly_count` is 0.
- R2: The signature is the `PAT_W` transmitted bits taken on the first `PAT_W` strobes after `sync_ok` is seen high while idle. The strobe after those serves as the transmit-side match and starts the count.
- R3: When the received stream equals the transmitted stream delayed by D strobes, the run finishes on strobe number `PAT_W`+1+D after `sync_ok` rose. It then shows `dly_valid`=1 and `dly_count`=D.
- R4: A loop delay of zero is measured as `dly_count`=0 with `dly_valid`=1, on strobe `PAT_W`+1.
- R5: Only `bit_en` strobes advance the capture and the counter. Idle clock cycles between strobes do not change the result. The flags only rise on a clock edge that carries a strobe.
- R6: While `sync_ok` stays high, a finished result keeps `dly_valid` and `dly_count` unchanged. One cycle after `sync_ok` goes low, both flags are 0.
- R7: For D equal to `TMO_LIMIT` the result is valid. For D greater than `TMO_LIMIT`, `dly_timeout` goes to 1 with `dly_valid`=0, on strobe `PAT_W`+1+`TMO_LIMIT`.
- R8: After `sync_ok` falls and rises again, a completely new measurement is made. Nothing from the previous run carries over.
- R9: `dly_valid` and `dly_timeout` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| sync_ok | input | 1 | Receive stream locked; high level enables measurement |
| tx_bit | input | 1 | Bit sent to the system under test |
| rx_bit | input | 1 | Bit received back from the system under test |
| dly_count | output | CNT_W | Measured loop delay in bit periods |
| dly_valid | output | 1 | Result valid, held until `sync_ok` drops |
| dly_timeout | output | 1 | Signature not returned in time |

## Verification
Suppose the signature is captured on the wrong strobe, or the counter is preloaded or advanced wrongly. Then every finished run reports a delay that is off by a fixed amount, and it is seen on the very first measurement. A sequencer that skips or repeats a state moves the strobe on which `dly_valid` rises. Counting strobes from the rise of `sync_ok` therefore catches it within one run. Flags that are not cleared, or a result that changes while held, show within one cycle of the `sync_ok` drop or during the hold interval.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_FILL    = 3'd1,
      ST_SEEK_TX = 3'd2,
      ST_RUN     = 3'd3,
      ST_HOLD    = 3'd4
   } ldm_state_e;
endpackage

// File: rtl/ldm_window.sv
module ldm_window #(
   parameter int W       = 64,
   parameter bit NEWEST_LSB = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] win
);
   generate
      if (W < 2) begin : g_bad_w
         $error("ldm_window: W must be at least 2");
      end
      if (NEWEST_LSB) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        win <= '0;
            else if (shift_en) win <= {win[W-2:0], din};
         end
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        win <= '0;
            else if (shift_en) win <= {din, win[W-1:1]};
         end
      end
   endgenerate
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
   import ldm_pkg::*;
#(
   parameter int PAT_W     = 64,
   parameter int TMO_LIMIT = 1 << 20,
   parameter bit NEWEST_LSB = 1'b1,
   parameter int CNT_W     = $clog2(TMO_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             sync_ok,
   input  logic             tx_bit,
   input  logic [PAT_W-1:0] tx_win,
   input  logic [PAT_W-1:0] rx_win,
   output logic [CNT_W-1:0] dly_count,
   output logic             dly_valid,
   output logic             dly_timeout
);
   localparam int FILL_W = $clog2(PAT_W);
   localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(PAT_W - 1);
   localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(TMO_LIMIT);

   ldm_state_e        state;
   logic [PAT_W-1:0]  sig_q;
   logic [PAT_W-1:0]  sig_next;
   logic [FILL_W-1:0] fill_q;
   logic [CNT_W-1:0]  run_q;
   logic              tx_hit;
   logic              rx_hit;

   generate
      if (NEWEST_LSB) begin : g_sig_lsb
         assign sig_next = {sig_q[PAT_W-2:0], tx_bit};
      end else begin : g_sig_msb
         assign sig_next = {tx_bit, sig_q[PAT_W-1:1]};
      end
   endgenerate

   assign tx_hit = (tx_win == sig_q);
   assign rx_hit = (rx_win == sig_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         sig_q       <= '0;
         fill_q      <= '0;
         run_q       <= '0;
         dly_count   <= '0;
         dly_valid   <= 1'b0;
         dly_timeout <= 1'b0;
      end else if (!sync_ok) begin
         state       <= ST_IDLE;
         fill_q      <= '0;
         run_q       <= '0;
         dly_count   <= '0;
         dly_valid   <= 1'b0;
         dly_timeout <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               fill_q <= '0;
               state  <= ST_FILL;
            end
            ST_FILL: begin
               if (bit_en) begin
                  sig_q <= sig_next;
                  if (fill_q == FILL_LAST) state  <= ST_SEEK_TX;
                  else                     fill_q <= fill_q + 1'b1;
               end
            end
            ST_SEEK_TX: begin
               if (bit_en && tx_hit) begin
                  if (rx_hit) begin
                     dly_count <= '0;
                     dly_valid <= 1'b1;
                     state     <= ST_HOLD;
                  end else begin
                     run_q <= CNT_W'(1);
                     state <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (bit_en) begin
                  if (rx_hit) begin
                     dly_count <= run_q;
                     dly_valid <= 1'b1;
                     state     <= ST_HOLD;
                  end else if (run_q == CNT_MAX) begin
                     dly_timeout <= 1'b1;
                     state       <= ST_HOLD;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end
            end
            default: state <= ST_HOLD;
         endcase
      end
   end
endmodule

// File: rtl/loop_delay_meter.sv
module loop_delay_meter #(
   parameter int PAT_W      = 64,
   parameter int TMO_LIMIT  = 1 << 20,
   parameter bit NEWEST_LSB = 1'b1,
   parameter int CNT_W      = $clog2(TMO_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             sync_ok,
   input  logic             tx_bit,
   input  logic             rx_bit,
   output logic [CNT_W-1:0] dly_count,
   output logic             dly_valid,
   output logic             dly_timeout
);
   logic [PAT_W-1:0] tx_win;
   logic [PAT_W-1:0] rx_win;

   generate
      if (PAT_W < 2) begin : g_bad_pat
         $error("loop_delay_meter: PAT_W must be at least 2");
      end
      if (TMO_LIMIT < 1) begin : g_bad_tmo
         $error("loop_delay_meter: TMO_LIMIT must be at least 1");
      end
      if (CNT_W < $clog2(TMO_LIMIT + 1)) begin : g_bad_cnt
         $error("loop_delay_meter: CNT_W too narrow for TMO_LIMIT");
      end
   endgenerate

   ldm_window #(.W(PAT_W), .NEWEST_LSB(NEWEST_LSB)) u_tx_win (
      .clk(clk), .rst_n(rst_n), .shift_en(bit_en), .din(tx_bit), .win(tx_win)
   );

   ldm_window #(.W(PAT_W), .NEWEST_LSB(NEWEST_LSB)) u_rx_win (
      .clk(clk), .rst_n(rst_n), .shift_en(bit_en), .din(rx_bit), .win(rx_win)
   );

   ldm_seq #(
      .PAT_W(PAT_W), .TMO_LIMIT(TMO_LIMIT), .NEWEST_LSB(NEWEST_LSB), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_ok(sync_ok),
      .tx_bit(tx_bit), .tx_win(tx_win), .rx_win(rx_win),
      .dly_count(dly_count), .dly_valid(dly_valid), .dly_timeout(dly_timeout)
   );
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
   parameter int TMO_LIMIT = 1 << 20,
   parameter int CNT_W     = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             sync_ok,
   input logic [CNT_W-1:0] dly_count,
   input logic             dly_valid,
   input logic             dly_timeout
);
   p_excl_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dly_valid && dly_timeout));

   p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |=> (!dly_valid && !dly_timeout));

   p_result_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_valid && $past(dly_valid)) |-> (dly_count == $past(dly_count)));

   p_valid_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dly_valid) |-> !$past(sync_ok));

   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dly_valid |-> (dly_count <= CNT_W'(TMO_LIMIT)));

   p_flag_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dly_valid) || $rose(dly_timeout)) |-> $past(bit_en));
endmodule

bind loop_delay_meter ldm_checker #(.TMO_LIMIT(TMO_LIMIT), .CNT_W(CNT_W)) u_ldm_checker (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_ok(sync_ok),
   .dly_count(dly_count), .dly_valid(dly_valid), .dly_timeout(dly_timeout)
);

// File: tb/loop_delay_meter_bench.sv
module loop_delay_meter_bench;
   localparam int PW  = 64;
   localparam int TMO = 300;
   localparam int CW  = $clog2(TMO + 1);
   localparam int NV  = 10;
   // each row: loop delay in strobes, idle cycles between strobes
   localparam int VEC [NV][2] = '{
      '{0, 0}, '{1, 0}, '{5, 2}, '{63, 0}, '{64, 1},
      '{200, 0}, '{300, 0}, '{301, 0}, '{350, 3}, '{17, 7}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_en = 1'b0;
   logic          sync_ok = 1'b0;
   logic          tx_bit = 1'b0;
   logic          rx_bit = 1'b0;
   logic [CW-1:0] dly_count;
   logic          dly_valid;
   logic          dly_timeout;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [22:0]  lfsr = 23'h5A5A5;
   logic [511:0] hist = '0;
   int cur_d = 0;

   always #5 clk = ~clk;

   loop_delay_meter #(.PAT_W(PW), .TMO_LIMIT(TMO)) u_loop_delay_meter (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_ok(sync_ok),
      .tx_bit(tx_bit), .rx_bit(rx_bit),
      .dly_count(dly_count), .dly_valid(dly_valid), .dly_timeout(dly_timeout)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one bit period: strobe for one cycle, then gap idle cycles
   task automatic tick(input int gap);
      logic nb;
      @(negedge clk);
      nb     = lfsr[22] ^ lfsr[4];
      lfsr   = {lfsr[21:0], nb};
      tx_bit = nb;
      rx_bit = (cur_d == 0) ? nb : hist[cur_d-1];
      hist   = {hist[510:0], nb};
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
   endtask

   task automatic measure(input int d, input int gap);
      int n;
      bit early;
      logic [CW-1:0] held;
      cur_d = d;
      early = 1'b0;
      sync_ok = 1'b0;
      for (int i = 0; i < d + 4; i++) tick(gap);
      // R6: flags clear while sync_ok is low
      chk(!dly_valid && !dly_timeout, "R6 flags low while unlocked", dly_valid, 0);
      @(negedge clk);
      sync_ok = 1'b1;
      @(negedge clk);
      n = 0;
      for (int i = 0; i < PW + TMO + 20; i++) begin
         tick(gap);
         n++;
         if (dly_valid || dly_timeout) break;
      end
      if (d <= TMO) begin
         // R3/R4: result value and finishing strobe
         chk(dly_valid == 1'b1 && dly_timeout == 1'b0, "R3 valid flag", dly_valid, 1);
         chk(dly_count == CW'(d), (d == 0) ? "R4 zero delay count" : "R3 delay count",
             dly_count, d);
         chk(n == PW + 1 + d, "R2 finishing strobe index", n, PW + 1 + d);
      end else begin
         // R7: timeout on strobe PW+1+TMO
         chk(dly_timeout == 1'b1 && dly_valid == 1'b0, "R7 timeout flag", dly_timeout, 1);
         chk(n == PW + 1 + TMO, "R7 timeout strobe index", n, PW + 1 + TMO);
      end
      // R6: result held while locked
      held = dly_count;
      for (int i = 0; i < 6; i++) tick(gap);
      chk(dly_count == held && (dly_valid || dly_timeout), "R6 result held",
          dly_count, held);
      @(negedge clk);
      sync_ok = 1'b0;
      @(negedge clk);
      chk(!dly_valid && !dly_timeout, "R6 flags cleared after drop",
          int'(dly_valid) + int'(dly_timeout), 0);
      if (early) chk(1'b0, "R3 early flag", 1, 0);
   endtask

   initial begin
      int cyc = 0;
      while (!finished && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dly_valid == 1'b0, "R1 valid after reset", dly_valid, 0);
      chk(dly_timeout == 1'b0, "R1 timeout after reset", dly_timeout, 0);
      chk(dly_count == '0, "R1 count after reset", dly_count, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R3, R4, R5 (gaps), R7 (limit and beyond), R8 (repeated runs)
      for (int v = 0; v < NV; v++) measure(VEC[v][0], VEC[v][1]);

      // R8: abort mid-run, then a fresh run gives the new delay
      cur_d = 9;
      @(negedge clk);
      sync_ok = 1'b1;
      for (int i = 0; i < PW + 3; i++) tick(0);
      @(negedge clk);
      sync_ok = 1'b0;
      @(negedge clk);
      chk(!dly_valid && !dly_timeout, "R8 aborted run leaves no result", dly_valid, 0);
      measure(12, 1);

      // R5: idle cycles without strobes after lock do not progress the run
      cur_d = 3;
      for (int i = 0; i < 8; i++) tick(0);
      @(negedge clk);
      sync_ok = 1'b1;
      repeat (400) @(negedge clk);
      chk(!dly_valid && !dly_timeout, "R5 no progress without strobes", dly_valid, 0);
      begin
         int n = 0;
         for (int i = 0; i < PW + 20; i++) begin
            tick(0);
            n++;
            if (dly_valid) break;
         end
         chk(dly_valid && dly_count == CW'(3), "R5 count after idle stretch", dly_count, 3);
         chk(n == PW + 4, "R5 strobe index after idle stretch", n, PW + 4);
      end
      @(negedge clk);
      sync_ok = 1'b0;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule